// File: doc/BRIEF.md
# Threshold Coincidence Trigger with Prescale

This block turns four sample streams into data triggers. Two of the streams are the summed values of the left and right calorimeter halves. The other two are the left and right scintillator channels. Each stream has a rising-edge discriminator with its own threshold. The calorimeter sums and the scintillators use separate threshold inputs. Each discriminator pulse then passes through a per-channel alignment delay, counted in 4 ns clock ticks, and a retriggerable stretcher. The stretcher width is set separately for the sums and for the scintillators.

Three coincidence units combine the stretched pulses:

- left: left calorimeter with left scintillator
- right: right calorimeter with right scintillator
- left-right: left calorimeter with right calorimeter

A coincidence fires only when the two stretched pulses overlap and the later one starts within a programmable window after the earlier one. Each coincidence type has its own prescaler, and a prescale of zero switches that trigger off. A copy of the left-right coincidence, delayed by a fixed number of ticks, feeds random-background counting. Accepted triggers are counted into blocks, and a ready flag is raised when a block is complete. The ready flag stays set until it is acknowledged.

All configuration arrives on plain input ports and is used as it stands each cycle. Every output is a registered single-cycle strobe, except the block-ready flag.

Top module: `coinc_trigger`

## Requirements
- R1: A discriminator fires once when its sample becomes greater than or equal to its threshold while the previous sample was below it. A sample held above the threshold does not fire again. The calorimeter sums compare against `thr_sum_l`/`thr_sum_r`, and the scintillators compare against `thr_sc_l`/`thr_sc_r`, independently.
- R2: Each channel has its own alignment delay of 1 to 255 ticks, and a setting of 0 acts as 1. The coincidence strobe rises exactly D+2 cycles after the clock edge that samples the crossing, where D is the delay of the later-aligned leg.
- R3: A stretched pulse lasts W ticks. W is `wid_sum` for the calorimeter channels and `wid_sc` for the scintillators, and any setting below 3 acts as 3. A new crossing during a stretch restarts the width count.
- R4: A coincidence fires when both stretched pulses are high together and the later pulse started no more than `win` ticks after the earlier one. A window of 0 acts as 1. Each overlap produces a single one-cycle strobe.
- R5: `coin_l` pairs the left calorimeter with the left scintillator, `coin_r` pairs the right calorimeter with the right scintillator, and `coin_lr` pairs the left and right calorimeters. No other combination produces these strobes.
- R6: With a prescale of N greater than 0, the trigger output of that type pulses on every Nth coincidence, one cycle after the coincidence strobe. With N equal to 0 that trigger never pulses.
- R7: A change of a prescale value resets that prescaler's count, so the next accepted trigger comes after N fresh coincidences.
- R8: `lr_bg` repeats each `coin_lr` strobe exactly BG_DLY ticks later (25 by default).
- R9: Every cycle that carries at least one accepted trigger increments the block count. When the count reaches `blk_size`, which must be nonzero, `blk_ready` rises one cycle after that trigger. The flag then holds, and triggers are not counted while it is set.
- R10: `ack` clears `blk_ready` on the next edge and restarts the block count from zero.
- R11: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cal_sum_l | input | SUM_W | Left calorimeter sum sample |
| cal_sum_r | input | SUM_W | Right calorimeter sum sample |
| sc_l | input | SAMP_W | Left scintillator sample |
| sc_r | input | SAMP_W | Right scintillator sample |
| thr_sum_l | input | SUM_W | Threshold for the left sum |
| thr_sum_r | input | SUM_W | Threshold for the right sum |
| thr_sc_l | input | SAMP_W | Threshold for the left scintillator |
| thr_sc_r | input | SAMP_W | Threshold for the right scintillator |
| dly_cal_l | input | TICK_W | Alignment delay, left sum |
| dly_cal_r | input | TICK_W | Alignment delay, right sum |
| dly_sc_l | input | TICK_W | Alignment delay, left scintillator |
| dly_sc_r | input | TICK_W | Alignment delay, right scintillator |
| wid_sum | input | TICK_W | Stretch width for both sums |
| wid_sc | input | TICK_W | Stretch width for both scintillators |
| win | input | TICK_W | Coincidence window in ticks |
| ps_l | input | PS_W | Prescale for the left trigger |
| ps_r | input | PS_W | Prescale for the right trigger |
| ps_lr | input | PS_W | Prescale for the left-right trigger |
| blk_size | input | BLK_W | Accepted triggers per block |
| ack | input | 1 | Clears the block-ready flag |
| coin_l | output | 1 | Left coincidence strobe |
| coin_r | output | 1 | Right coincidence strobe |
| coin_lr | output | 1 | Left-right coincidence strobe |
| trig_l | output | 1 | Accepted left trigger |
| trig_r | output | 1 | Accepted right trigger |
| trig_lr | output | 1 | Accepted left-right trigger |
| lr_bg | output | 1 | Delayed left-right strobe for background counting |
| blk_ready | output | 1 | Block complete, held until ack |

## Verification
On every cycle, the assertions check these local properties:

- A discriminator pulse never repeats on consecutive cycles.
- A delayed tap always starts a stretch.
- A coincidence strobe follows a cycle in which both legs were high, and it never lasts two cycles.
- An accepted trigger always follows a coincidence and a nonzero prescale.
- The ready flag holds until `ack`, and `ack` clears it.

The exact latencies depend on the settings. Which gap and width combinations fire, how prescale counts and their resets space the triggers, the background delay, and the block count restarting after `ack` can only be shown by the bench's timed scenarios. The bench compares every strobe against the cycle predicted from the requirements.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam int SUM_W_D  = 16;
    localparam int SAMP_W_D = 12;
    localparam int TICK_W_D = 8;
    localparam int PS_W_D   = 11;
    localparam int BLK_W_D  = 8;
    localparam int BG_DLY_D = 25;
    localparam int NCH      = 4;
    localparam int NKIND    = 3;
    localparam int MIN_WID  = 3;

    typedef enum logic [1:0] {
        CH_CAL_L = 2'd0,
        CH_CAL_R = 2'd1,
        CH_SC_L  = 2'd2,
        CH_SC_R  = 2'd3
    } chan_e;

    typedef enum logic [1:0] {
        K_L  = 2'd0,
        K_R  = 2'd1,
        K_LR = 2'd2
    } kind_e;

    // one bit per trigger kind, left in bit 0
    typedef struct packed {
        logic lr;
        logic r;
        logic l;
    } trio_t;

    // replaces a setting below lo by lo
    function automatic logic [TICK_W_D-1:0] floor_to(input logic [TICK_W_D-1:0] v,
                                                     input logic [TICK_W_D-1:0] lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/ct_chan.sv
module ct_chan
    import ct_pkg::*;
#(
    parameter int VAL_W = SUM_W_D,
    parameter int TW    = TICK_W_D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] sample,
    input  logic [VAL_W-1:0] thr,
    input  logic [TW-1:0]    dly,
    input  logic [TW-1:0]    wid,
    output logic             level
);
    localparam int LINE = (1 << TW) - 1;

    logic            above, prev_above, hit_q, tap;
    logic [LINE-1:0] line;
    logic [TW-1:0]   dly_eff, wid_eff, cnt;

    always_comb begin
        above   = (sample >= thr);
        dly_eff = (dly == '0) ? TW'(1) : dly;
        wid_eff = (wid < TW'(MIN_WID)) ? TW'(MIN_WID) : wid;
        tap     = line[dly_eff - 1'b1];
        level   = (cnt != '0);
    end

    // rising-crossing discriminator
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_above <= 1'b0;
            hit_q      <= 1'b0;
        end else begin
            prev_above <= above;
            hit_q      <= above & ~prev_above;
        end
    end

    // alignment delay line, tapped at the programmed depth
    always_ff @(posedge clk) begin
        if (rst) line <= '0;
        else     line <= {line[LINE-2:0], hit_q};
    end

    // retriggerable stretcher
    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (tap)          cnt <= wid_eff;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    AST_HIT_ONE_SHOT: assert property (@(posedge clk) disable iff (rst) hit_q |=> !hit_q) else $error("discriminator repeated"); // R1
    AST_STRETCH_START: assert property (@(posedge clk) disable iff (rst) tap |=> level) else $error("tap did not start stretch"); // R3

endmodule

// File: rtl/ct_coinc.sv
module ct_coinc
    import ct_pkg::*;
#(
    parameter int TW = TICK_W_D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lvl_a,
    input  logic          lvl_b,
    input  logic [TW-1:0] win,
    output logic          fire_q
);
    logic          pa, pb, rise_a, rise_b, and_rise, in_win, fire;
    logic [TW-1:0] wa, wb, win_eff;

    always_comb begin
        win_eff  = (win == '0) ? TW'(1) : win;
        rise_a   = lvl_a & ~pa;
        rise_b   = lvl_b & ~pb;
        and_rise = lvl_a & lvl_b & ~(pa & pb);
        // the leg that did not just start must have started inside the window
        in_win   = rise_a ? (rise_b | (wb != '0)) : (wa != '0);
        fire     = and_rise & in_win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pa     <= 1'b0;
            pb     <= 1'b0;
            wa     <= '0;
            wb     <= '0;
            fire_q <= 1'b0;
        end else begin
            pa     <= lvl_a;
            pb     <= lvl_b;
            fire_q <= fire;
            if (rise_a)          wa <= win_eff;
            else if (wa != '0)   wa <= wa - 1'b1;
            if (rise_b)          wb <= win_eff;
            else if (wb != '0)   wb <= wb - 1'b1;
        end
    end

    AST_COIN_SINGLE: assert property (@(posedge clk) disable iff (rst) fire_q |=> !fire_q) else $error("coincidence lasted two cycles"); // R4
    AST_COIN_BOTH: assert property (@(posedge clk) disable iff (rst) fire_q |-> $past(lvl_a && lvl_b)) else $error("coincidence without both legs"); // R5

endmodule

// File: rtl/ct_prescale.sv
module ct_prescale
    import ct_pkg::*;
#(
    parameter int PW = PS_W_D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          coin,
    input  logic [PW-1:0] n,
    output logic          acc_q
);
    logic [PW-1:0] cnt, n_q;
    logic [PW:0]   nxt;

    always_comb nxt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            n_q   <= '0;
            acc_q <= 1'b0;
        end else begin
            n_q   <= n;
            acc_q <= 1'b0;
            if (n != n_q) begin
                cnt <= '0;
            end else if (coin && n != '0) begin
                if (nxt >= {1'b0, n}) begin
                    acc_q <= 1'b1;
                    cnt   <= '0;
                end else begin
                    cnt <= nxt[PW-1:0];
                end
            end
        end
    end

    AST_PS_FROM_COIN: assert property (@(posedge clk) disable iff (rst) acc_q |-> $past(coin)) else $error("trigger without coincidence"); // R6
    AST_PS_ZERO_OFF: assert property (@(posedge clk) disable iff (rst) acc_q |-> $past(n) != '0) else $error("trigger with prescale 0"); // R6

endmodule

// File: rtl/ct_block.sv
module ct_block
    import ct_pkg::*;
#(
    parameter int BW = BLK_W_D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc,
    input  logic [BW-1:0] size,
    input  logic          ack,
    output logic          ready
);
    logic [BW-1:0] cnt;
    logic [BW:0]   nxt;

    always_comb nxt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (ack) begin
            cnt   <= '0;
            ready <= 1'b0;
        end else if (acc && !ready && size != '0) begin
            cnt <= nxt[BW-1:0];
            if (nxt == {1'b0, size}) ready <= 1'b1;
        end
    end

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst) (ready && !ack) |=> ready) else $error("ready dropped without ack"); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst) ack |=> !ready) else $error("ack did not clear ready"); // R10

endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger
    import ct_pkg::*;
#(
    parameter int SUM_W  = SUM_W_D,
    parameter int SAMP_W = SAMP_W_D,
    parameter int TICK_W = TICK_W_D,
    parameter int PS_W   = PS_W_D,
    parameter int BLK_W  = BLK_W_D,
    parameter int BG_DLY = BG_DLY_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SUM_W-1:0]  cal_sum_l,
    input  logic [SUM_W-1:0]  cal_sum_r,
    input  logic [SAMP_W-1:0] sc_l,
    input  logic [SAMP_W-1:0] sc_r,
    input  logic [SUM_W-1:0]  thr_sum_l,
    input  logic [SUM_W-1:0]  thr_sum_r,
    input  logic [SAMP_W-1:0] thr_sc_l,
    input  logic [SAMP_W-1:0] thr_sc_r,
    input  logic [TICK_W-1:0] dly_cal_l,
    input  logic [TICK_W-1:0] dly_cal_r,
    input  logic [TICK_W-1:0] dly_sc_l,
    input  logic [TICK_W-1:0] dly_sc_r,
    input  logic [TICK_W-1:0] wid_sum,
    input  logic [TICK_W-1:0] wid_sc,
    input  logic [TICK_W-1:0] win,
    input  logic [PS_W-1:0]   ps_l,
    input  logic [PS_W-1:0]   ps_r,
    input  logic [PS_W-1:0]   ps_lr,
    input  logic [BLK_W-1:0]  blk_size,
    input  logic              ack,
    output logic              coin_l,
    output logic              coin_r,
    output logic              coin_lr,
    output logic              trig_l,
    output logic              trig_r,
    output logic              trig_lr,
    output logic              lr_bg,
    output logic              blk_ready
);
    logic [SUM_W-1:0]  val [NCH];
    logic [SUM_W-1:0]  thr [NCH];
    logic [TICK_W-1:0] dly [NCH];
    logic [TICK_W-1:0] wid [NCH];
    logic [NCH-1:0]    lvl;

    logic [NKIND-1:0]  leg_a, leg_b, fire, acc;
    logic [PS_W-1:0]   ps_arr [NKIND];
    logic [BG_DLY-1:0] bg_line;
    trio_t             coin_s, trig_s;

    always_comb begin
        val[CH_CAL_L] = cal_sum_l;
        val[CH_CAL_R] = cal_sum_r;
        val[CH_SC_L]  = SUM_W'(sc_l);
        val[CH_SC_R]  = SUM_W'(sc_r);
        thr[CH_CAL_L] = thr_sum_l;
        thr[CH_CAL_R] = thr_sum_r;
        thr[CH_SC_L]  = SUM_W'(thr_sc_l);
        thr[CH_SC_R]  = SUM_W'(thr_sc_r);
        dly[CH_CAL_L] = dly_cal_l;
        dly[CH_CAL_R] = dly_cal_r;
        dly[CH_SC_L]  = dly_sc_l;
        dly[CH_SC_R]  = dly_sc_r;
        wid[CH_CAL_L] = wid_sum;
        wid[CH_CAL_R] = wid_sum;
        wid[CH_SC_L]  = wid_sc;
        wid[CH_SC_R]  = wid_sc;
        // coincidence leg pairing
        leg_a[K_L]    = lvl[CH_CAL_L];
        leg_b[K_L]    = lvl[CH_SC_L];
        leg_a[K_R]    = lvl[CH_CAL_R];
        leg_b[K_R]    = lvl[CH_SC_R];
        leg_a[K_LR]   = lvl[CH_CAL_L];
        leg_b[K_LR]   = lvl[CH_CAL_R];
        ps_arr[K_L]   = ps_l;
        ps_arr[K_R]   = ps_r;
        ps_arr[K_LR]  = ps_lr;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ct_chan #(.VAL_W(SUM_W), .TW(TICK_W)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .sample (val[g]),
            .thr    (thr[g]),
            .dly    (dly[g]),
            .wid    (wid[g]),
            .level  (lvl[g])
        );
    end

    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        ct_coinc #(.TW(TICK_W)) u_coinc (
            .clk    (clk),
            .rst    (rst),
            .lvl_a  (leg_a[k]),
            .lvl_b  (leg_b[k]),
            .win    (win),
            .fire_q (fire[k])
        );
        ct_prescale #(.PW(PS_W)) u_ps (
            .clk    (clk),
            .rst    (rst),
            .coin   (fire[k]),
            .n      (ps_arr[k]),
            .acc_q  (acc[k])
        );
    end

    // background copy of the left-right coincidence
    always_ff @(posedge clk) begin
        if (rst) bg_line <= '0;
        else     bg_line <= {bg_line[BG_DLY-2:0], fire[K_LR]};
    end

    ct_block #(.BW(BLK_W)) u_block (
        .clk   (clk),
        .rst   (rst),
        .acc   (|acc),
        .size  (blk_size),
        .ack   (ack),
        .ready (blk_ready)
    );

    assign coin_s  = fire;
    assign trig_s  = acc;
    assign coin_l  = coin_s.l;
    assign coin_r  = coin_s.r;
    assign coin_lr = coin_s.lr;
    assign trig_l  = trig_s.l;
    assign trig_r  = trig_s.r;
    assign trig_lr = trig_s.lr;
    assign lr_bg   = bg_line[BG_DLY-1];

endmodule

// File: tb/coinc_trigger_test.sv
module coinc_trigger_test;

    logic        clk = 1'b0, rst = 1'b1;
    logic [15:0] cal_sum_l = '0, cal_sum_r = '0, thr_sum_l = 16'd1000, thr_sum_r = 16'd1000;
    logic [11:0] sc_l = '0, sc_r = '0, thr_sc_l = 12'd400, thr_sc_r = 12'd400;
    logic [7:0]  dly_cal_l = 8'd2, dly_cal_r = 8'd2, dly_sc_l = 8'd2, dly_sc_r = 8'd2;
    logic [7:0]  wid_sum = 8'd3, wid_sc = 8'd3, win = 8'd2;
    logic [10:0] ps_l = 11'd1, ps_r = 11'd1, ps_lr = 11'd1;
    logic [7:0]  blk_size = '0;
    logic        ack = 1'b0;
    logic        coin_l, coin_r, coin_lr, trig_l, trig_r, trig_lr, lr_bg, blk_ready;

    always #2 clk = ~clk;

    coinc_trigger uut (.*);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int at; logic [6:0] m; string tag; } exp_t;
    exp_t q[$];
    int checks = 0, errs = 0;
    bit done = 0;
    string phase = "R11";
    logic [15:0] hi_cal = 16'd1200;
    logic [11:0] hi_sc = 12'd600;

    task automatic expect_at(input int at, input logic [6:0] m, input string tag);
        exp_t e;
        e.at = at; e.m = m; e.tag = tag;
        q.push_back(e);
    endtask

    // mask bits: 0 coin_l, 1 coin_r, 2 coin_lr, 3 trig_l, 4 trig_r, 5 trig_lr, 6 lr_bg
    task automatic expect_coin(input int c, input int d, input logic [2:0] k,
                               input logic [2:0] a, input string tag);
        expect_at(c + d + 3, {4'b0, k}, tag);
        if (a != 3'b0) expect_at(c + d + 4, {1'b0, a, 3'b0}, tag);
        if (k[2]) expect_at(c + d + 3 + 25, 7'b1000000, {tag, " R8"});
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [6:0] obs, expm;
            string tag;
            obs  = {lr_bg, trig_lr, trig_r, trig_l, coin_lr, coin_r, coin_l};
            expm = '0;
            tag  = phase;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].at == cyc) begin
                    expm |= q[i].m;
                    tag = q[i].tag;
                    q.delete(i);
                end
            end
            if (obs != 7'b0 || expm != 7'b0) begin
                checks++;
                if (obs !== expm) begin
                    errs++;
                    $display("FAIL %s: strobes %b expected %b at cycle %0d", tag, obs, expm, cyc);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic ex);
        checks++;
        if (act !== ex) begin
            errs++;
            $display("FAIL %s: got %b expected %b at cycle %0d", tag, act, ex, cyc);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // chm bits: 0 cal_l, 1 cal_r, 2 sc_l, 3 sc_r; one-cycle crossing
    task automatic hit(input logic [3:0] chm, output int c);
        c = cyc;
        if (chm[0]) cal_sum_l = hi_cal;
        if (chm[1]) cal_sum_r = hi_cal;
        if (chm[2]) sc_l = hi_sc;
        if (chm[3]) sc_r = hi_sc;
        @(negedge clk);
        cal_sum_l = '0; cal_sum_r = '0; sc_l = '0; sc_r = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        int c, c2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 coin_l", coin_l, 1'b0);   chk("R11 coin_r", coin_r, 1'b0);
        chk("R11 coin_lr", coin_lr, 1'b0); chk("R11 trig_l", trig_l, 1'b0);
        chk("R11 trig_r", trig_r, 1'b0);   chk("R11 trig_lr", trig_lr, 1'b0);
        chk("R11 lr_bg", lr_bg, 1'b0);     chk("R11 blk_ready", blk_ready, 1'b0);
        idle(5);

        // R5 pairings, R8 background copy
        phase = "R5";
        hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b001, "R5 left"); idle(40);
        hit(4'b1010, c); expect_coin(c, 2, 3'b010, 3'b010, "R5 right"); idle(40);
        hit(4'b0011, c); expect_coin(c, 2, 3'b100, 3'b100, "R5 left-right"); idle(40);
        hit(4'b1111, c); expect_coin(c, 2, 3'b111, 3'b111, "R5 all legs"); idle(40);
        hit(4'b0110, c); idle(40); // cal_r with sc_l pairs nothing (R5)

        // R1 thresholds
        phase = "R1";
        hi_cal = 16'd999;
        hit(4'b0101, c); wait_until(c + 5); chk("R1 sum below threshold", coin_l, 1'b0); idle(40);
        hi_cal = 16'd1000;
        hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b001, "R1 sum equal threshold"); idle(40);
        hi_cal = 16'd1200; thr_sc_l = 12'd700;
        hit(4'b0101, c); wait_until(c + 5); chk("R1 scint own threshold", coin_l, 1'b0); idle(40);
        thr_sc_l = 12'd400;
        c = cyc; cal_sum_l = hi_cal; sc_l = hi_sc;
        expect_coin(c, 2, 3'b001, 3'b001, "R1 held above fires once");
        idle(6); cal_sum_l = '0; sc_l = '0; idle(40);

        // R2 alignment delays
        phase = "R2";
        dly_sc_l = 8'd5;
        hit(4'b0100, c); idle(2); hit(4'b0001, c2);
        expect_coin(c2, 2, 3'b001, 3'b001, "R2 aligned legs"); idle(40);
        dly_sc_l = 8'd2;
        hit(4'b0100, c); idle(2); hit(4'b0001, c2);
        wait_until(c2 + 5); chk("R2 misaligned legs", coin_l, 1'b0); idle(40);
        dly_cal_l = 8'd0; dly_sc_l = 8'd0;
        hit(4'b0101, c); expect_coin(c, 1, 3'b001, 3'b001, "R2 delay zero acts as one"); idle(40);
        dly_cal_l = 8'd2; dly_sc_l = 8'd2;

        // R4 window
        phase = "R4";
        wid_sum = 8'd20; wid_sc = 8'd20; win = 8'd4;
        hit(4'b0100, c); idle(3); hit(4'b0001, c2);
        expect_coin(c2, 2, 3'b001, 3'b001, "R4 gap equal window"); idle(40);
        hit(4'b0001, c); idle(4); hit(4'b0100, c2);
        wait_until(c2 + 5); chk("R4 gap beyond window", coin_l, 1'b0); idle(40);
        win = 8'd0;
        hit(4'b0100, c); hit(4'b0001, c2);
        expect_coin(c2, 2, 3'b001, 3'b001, "R4 window zero gap one"); idle(40);
        hit(4'b0100, c); idle(1); hit(4'b0001, c2);
        wait_until(c2 + 5); chk("R4 window zero gap two", coin_l, 1'b0); idle(40);

        // R3 stretch width
        phase = "R3";
        win = 8'd10; wid_sum = 8'd20; wid_sc = 8'd3;
        hit(4'b0100, c); idle(2); hit(4'b0001, c2);
        wait_until(c2 + 5); chk("R3 scint width 3 expired", coin_l, 1'b0); idle(40);
        wid_sc = 8'd4;
        hit(4'b0100, c); idle(2); hit(4'b0001, c2);
        expect_coin(c2, 2, 3'b001, 3'b001, "R3 scint width 4"); idle(40);
        wid_sc = 8'd1;
        hit(4'b0100, c); idle(1); hit(4'b0001, c2);
        expect_coin(c2, 2, 3'b001, 3'b001, "R3 width floor 3"); idle(40);
        wid_sc = 8'd3;
        hit(4'b0100, c); idle(1); hit(4'b0100, c); idle(1); hit(4'b0001, c2);
        expect_coin(c2, 2, 3'b001, 3'b001, "R3 retrigger restart"); idle(40);
        wid_sum = 8'd3; win = 8'd2;

        // R6 prescale
        phase = "R6";
        ps_l = 11'd3; idle(3);
        for (int i = 0; i < 6; i++) begin
            hit(4'b0101, c);
            expect_coin(c, 2, 3'b001, (i % 3 == 2) ? 3'b001 : 3'b000, "R6 every third");
            idle(12);
        end
        ps_l = 11'd0; idle(3);
        hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b000, "R6 prescale zero");
        wait_until(c + 6); chk("R6 prescale zero trig_l", trig_l, 1'b0); idle(12);

        // R7 prescale change resets count
        phase = "R7";
        ps_l = 11'd3; idle(3);
        for (int i = 0; i < 2; i++) begin
            hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b000, "R7 before change"); idle(12);
        end
        ps_l = 11'd2; idle(3);
        hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b000, "R7 first after change"); idle(12);
        hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b001, "R7 second after change"); idle(12);

        // R9 / R10 blocks
        phase = "R9";
        ps_l = 11'd1; blk_size = 8'd3; idle(3);
        for (int i = 0; i < 2; i++) begin
            hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b001, "R9 count");
            wait_until(c + 7); chk("R9 not yet full", blk_ready, 1'b0); idle(8);
        end
        hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b001, "R9 filling");
        wait_until(c + 6); chk("R9 ready one cycle after trigger", blk_ready, 1'b0);
        wait_until(c + 7); chk("R9 block full", blk_ready, 1'b1); idle(8);
        hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b001, "R9 while ready");
        wait_until(c + 12); chk("R9 ready holds", blk_ready, 1'b1);
        phase = "R10";
        ack = 1'b1; idle(1); ack = 1'b0;
        chk("R10 ack clears", blk_ready, 1'b0);
        for (int i = 0; i < 2; i++) begin
            hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b001, "R10 recount");
            wait_until(c + 7); chk("R10 count restarted", blk_ready, 1'b0); idle(8);
        end
        hit(4'b0101, c); expect_coin(c, 2, 3'b001, 3'b001, "R10 refill");
        wait_until(c + 7); chk("R10 second block full", blk_ready, 1'b1);
        ack = 1'b1; idle(1); ack = 1'b0; idle(40);

        done = 1;
        foreach (q[i]) begin
            errs++;
            $display("FAIL %s: strobes %b never seen, expected at cycle %0d", q[i].tag, 7'b0, q[i].at);
        end
        summary();
        $finish;
    end

endmodule